// File: doc/BRIEF.md
# APB Down-Counting Timer Bank

This block holds a parameterised number of independent 32-bit down-counters behind a zero-wait-state APB slave port. Software programs each counter with a start value, a mode and an interrupt mask, then enables it. When a running counter is about to reach zero it reloads and raises a pending flag. In periodic mode the reload value is the programmed start value. In free-running mode the reload value is all ones, so software can measure elapsed time as the bitwise inverse of the current value.

Each counter is a two-state machine. In `ST_OFF` the count holds. The transition `ST_OFF -> ST_RUN` (named *arm*) fires on the first clock after the enable bit becomes 1, and it copies the start value into the count. In `ST_RUN` the count steps down once per clock. The transition `ST_RUN -> ST_RUN` (named *wrap*) fires when the count is 0 or 1: the count reloads and the pending flag is set. The transition `ST_RUN -> ST_OFF` (named *halt*) fires on the first clock after the enable bit becomes 0. Each counter drives its own interrupt line, which is the pending flag gated by the mask. A shared line is the OR of all the per-counter lines. Reading a counter's acknowledge register clears that counter's pending flag. Reading the shared acknowledge register clears every pending flag.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every start value, count, control field and pending flag is zero, and `tmr_irq` and `irq_any` are low.
- R2: Counter n occupies byte addresses n*0x14 + {0x00 start value, 0x04 current count, 0x08 control, 0x0C acknowledge, 0x10 masked status}. The shared registers are 0xA0 masked status vector, 0xA4 shared acknowledge, 0xA8 raw pending vector and 0xAC version word. Any other address, including addresses with bits [1:0] not zero, reads as zero, and `pready` is always 1.
- R3: Control bit 0 is the enable, bit 1 selects periodic mode (1) or free-running mode (0), and bit 2 is the interrupt mask (1 = masked). The start value and the control field read back as written.
- R4: The clock after enable becomes 1 while in `ST_OFF` loads the count from the start value. After that, the count falls by one per clock. Writing the control register again with enable still 1 does not reload the count.
- R5: In periodic mode with start value L (L >= 1), the count after k running clocks is L - (k mod L), and the pending flag is set once k >= L.
- R6: In free-running mode, a count of 1 (or 0) reloads 0xFFFFFFFF and sets the pending flag.
- R7: While enable is 0, the count holds its value and the pending flag is not set.
- R8: With the mask set, the counter still runs and sets its raw pending bit, but its interrupt line, its status register and its bit at 0xA0 stay 0. Clearing the mask exposes the pending flag on `tmr_irq` and `irq_any`.
- R9: A read of a counter's acknowledge register returns zero and clears that counter's pending flag. If a wrap happens in the same clock, the wrap wins and the flag stays set.
- R10: A read of 0xA4 returns the masked status vector and clears every pending flag.
- R11: 0xAC returns the `VERSION` parameter, and `irq_any` is the OR of all `tmr_irq` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid during the access phase |
| pready | output | 1 | Always 1 |
| tmr_irq | output | NUM_TMR | Per-counter masked interrupt |
| irq_any | output | 1 | OR of all counter interrupts |

## Verification
A wrong state or a wrong count shows up as a frozen count value that differs arithmetically from L - (k mod L), or from the free-running formula. This becomes visible at the first read after the counter is halted. A reload taken one clock early or late therefore moves the frozen value by one.

A pending flag that is set or cleared at the wrong time appears at once on `tmr_irq` or in the raw vector at 0xA8. A decode fault shows up in the next read of a neighbouring or unmapped address.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } tmr_state_t;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_LOAD,
        RK_CUR,
        RK_CTRL,
        RK_ACK,
        RK_STAT,
        RK_GSTAT,
        RK_GACK,
        RK_RAW,
        RK_VER
    } reg_kind_t;

    localparam int BLK_BYTES  = 'h14;
    localparam int OFS_LOAD   = 'h00;
    localparam int OFS_CUR    = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_ACK    = 'h0C;
    localparam int OFS_STAT   = 'h10;
    localparam int ADR_GSTAT  = 'hA0;
    localparam int ADR_GACK   = 'hA4;
    localparam int ADR_RAW    = 'hA8;
    localparam int ADR_VER    = 'hAC;

    localparam int CTL_EN     = 0;
    localparam int CTL_PER    = 1;
    localparam int CTL_MASK   = 2;
    localparam int CTL_W      = 3;

endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_t         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] BLK_A = ADDR_W'(BLK_BYTES);

    logic [ADDR_W-1:0] base_a;
    logic [ADDR_W-1:0] off_a;

    always_comb begin
        kind   = RK_NONE;
        idx    = '0;
        base_a = '0;
        off_a  = '0;
        if (addr[1:0] == 2'b00) begin
            for (int n = 0; n < NUM_TMR; n++) begin
                base_a = ADDR_W'(BLK_BYTES * n);
                off_a  = addr - base_a;
                if (addr >= base_a && off_a < BLK_A) begin
                    idx = n[IDX_W-1:0];
                    case (off_a)
                        ADDR_W'(OFS_LOAD): kind = RK_LOAD;
                        ADDR_W'(OFS_CUR):  kind = RK_CUR;
                        ADDR_W'(OFS_CTRL): kind = RK_CTRL;
                        ADDR_W'(OFS_ACK):  kind = RK_ACK;
                        ADDR_W'(OFS_STAT): kind = RK_STAT;
                        default:           kind = RK_NONE;
                    endcase
                end
            end
            case (addr)
                ADDR_W'(ADR_GSTAT): kind = RK_GSTAT;
                ADDR_W'(ADR_GACK):  kind = RK_GACK;
                ADDR_W'(ADR_RAW):   kind = RK_RAW;
                ADDR_W'(ADR_VER):   kind = RK_VER;
                default:            ;
            endcase
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_clr,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cur_q,
    output logic [CTL_W-1:0]  ctrl_q,
    output logic              pend_q,
    output logic              irq
);

    tmr_state_t        state_q, state_d;
    logic [DATA_W-1:0] cur_d;
    logic              wrap;

    // next state and next count
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        wrap    = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (ctrl_q[CTL_EN]) begin
                    state_d = ST_RUN;
                    cur_d   = load_q;
                end
            end
            ST_RUN: begin
                if (!ctrl_q[CTL_EN]) begin
                    state_d = ST_OFF;
                end else if (cur_q <= DATA_W'(1)) begin
                    wrap  = 1'b1;
                    cur_d = ctrl_q[CTL_PER] ? load_q : '1;
                end else begin
                    cur_d = cur_q - DATA_W'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            cur_q  <= '0;
            ctrl_q <= '0;
            pend_q <= 1'b0;
        end else begin
            cur_q  <= cur_d;
            pend_q <= wrap | (pend_q & ~ack_clr);
            if (wr_load) load_q <= wdata;
            if (wr_ctrl) ctrl_q <= wdata[CTL_W-1:0];
        end
    end

    assign irq = pend_q & ~ctrl_q[CTL_MASK];

    // R4
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && ctrl_q[CTL_EN]) |=> (state_q == ST_RUN && cur_q == $past(load_q)));

    // R5
    periodic_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctrl_q[CTL_EN] && ctrl_q[CTL_PER] && cur_q == DATA_W'(1))
        |=> (cur_q == $past(load_q) && pend_q));

    // R6
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctrl_q[CTL_EN] && !ctrl_q[CTL_PER] && cur_q == DATA_W'(1))
        |=> (&cur_q && pend_q));

    // R7
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !ctrl_q[CTL_EN]) |=> ($stable(cur_q) && !$rose(pend_q)));

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && state_q == ST_OFF) |=> !pend_q);

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int          NUM_TMR = 2,
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] VERSION = 32'h3230_352A,
    localparam int         IDX_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    output logic               pready,
    output logic [NUM_TMR-1:0] tmr_irq,
    output logic               irq_any
);

    reg_kind_t         kind;
    logic [IDX_W-1:0]  idx;
    logic              wr_en, rd_en;
    logic [DATA_W-1:0] load_a [NUM_TMR];
    logic [DATA_W-1:0] cur_a  [NUM_TMR];
    logic [CTL_W-1:0]  ctrl_a [NUM_TMR];
    logic [NUM_TMR-1:0] pend_vec;

    assign wr_en  = psel & penable & pwrite;
    assign rd_en  = psel & penable & ~pwrite;
    assign pready = 1'b1;

    tmr_addr_decode #(
        .NUM_TMR (NUM_TMR),
        .ADDR_W  (ADDR_W)
    ) i_dec (
        .addr (paddr),
        .kind (kind),
        .idx  (idx)
    );

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
        logic sel_me;
        assign sel_me = (idx == IDX_W'(n));

        tmr_channel #(
            .DATA_W (DATA_W)
        ) i_chan (
            .clk     (pclk),
            .rst_n   (presetn),
            .wr_load (wr_en && kind == RK_LOAD && sel_me),
            .wr_ctrl (wr_en && kind == RK_CTRL && sel_me),
            .wdata   (pwdata),
            .ack_clr (rd_en && ((kind == RK_ACK && sel_me) || kind == RK_GACK)),
            .load_q  (load_a[n]),
            .cur_q   (cur_a[n]),
            .ctrl_q  (ctrl_a[n]),
            .pend_q  (pend_vec[n]),
            .irq     (tmr_irq[n])
        );
    end

    assign irq_any = |tmr_irq;

    always_comb begin
        case (kind)
            RK_LOAD:  prdata = load_a[idx];
            RK_CUR:   prdata = cur_a[idx];
            RK_CTRL:  prdata = DATA_W'(ctrl_a[idx]);
            RK_STAT:  prdata = DATA_W'(tmr_irq[idx]);
            RK_GSTAT: prdata = DATA_W'(tmr_irq);
            RK_GACK:  prdata = DATA_W'(tmr_irq);
            RK_RAW:   prdata = DATA_W'(pend_vec);
            RK_VER:   prdata = DATA_W'(VERSION);
            default:  prdata = '0;
        endcase
    end

    // R10
    global_ack_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_en && kind == RK_GACK && ctrl_a[0][CTL_EN] == 1'b0) |=> !pend_vec[0]);

endmodule

// File: tb/test_tick_timer_bank.sv
module test_tick_timer_bank;

    localparam int          NT  = 2;
    localparam int          AW  = 8;
    localparam int          DW  = 32;
    localparam logic [31:0] VER = 32'h3230_352A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          pready;
    logic [NT-1:0] tmr_irq;
    logic          irq_any;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_wr = 0;
    bit done  = 1'b0;

    tick_timer_bank #(.NUM_TMR(NT), .ADDR_W(AW), .DATA_W(DW), .VERSION(VER)) i_tick_timer_bank (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .tmr_irq(tmr_irq), .irq_any(irq_any)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        last_wr = cyc;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [31:0] exp_cur(int l, int k, bit per);
        if (per)     return 32'(l - (k % l));
        else if (k < l) return 32'(l - k);
        else         return 32'hFFFF_FFFF - 32'(k - l);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int e, d, k;
        int lens [5] = '{1, 2, 3, 5, 7};
        int waits [4] = '{0, 2, 5, 11};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {30'd0, irq_any, tmr_irq[0]}, 32'd0);
        rd(8'h04, v); chk("R1 cur", v, 0);
        rd(8'h08, v); chk("R1 ctrl", v, 0);
        rd(8'hA8, v); chk("R1 raw", v, 0);

        // R3 readback
        wr(8'h00, 32'hDEAD_BEEF); rd(8'h00, v); chk("R3 load", v, 32'hDEAD_BEEF);
        wr(8'h08, 32'h6); rd(8'h08, v); chk("R3 ctrl", v, 32'h6);
        wr(8'h08, 32'h0);

        // R5 / R4 / R9 periodic sweep on timer 0
        foreach (lens[i]) begin
            foreach (waits[j]) begin
                wr(8'h00, 32'(lens[i]));
                wr(8'h08, 32'h3); e = last_wr;
                repeat (waits[j]) @(negedge clk);
                wr(8'h08, 32'h2); d = last_wr;
                k = d - e - 1;
                rd(8'h04, v);  chk("R5 count", v, exp_cur(lens[i], k, 1'b1));
                rd(8'hA8, v);  chk("R5 pend", v, {31'd0, k >= lens[i]});
                rd(8'h0C, v);  chk("R9 ack data", v, 0);
                rd(8'hA8, v);  chk("R9 cleared", v, 0);
            end
        end

        // R6 free-running
        for (int l = 2; l <= 4; l += 2) begin
            for (int w = 1; w <= 6; w += 5) begin
                wr(8'h00, 32'(l));
                wr(8'h08, 32'h1); e = last_wr;
                repeat (w) @(negedge clk);
                wr(8'h08, 32'h0); d = last_wr;
                k = d - e - 1;
                rd(8'h04, v); chk("R6 count", v, exp_cur(l, k, 1'b0));
                rd(8'h0C, v);
            end
        end

        // R7 hold while disabled
        rd(8'h04, v);
        repeat (10) @(negedge clk);
        rd(8'h04, v2); chk("R7 hold", v2, v);
        chk("R7 no irq", {31'd0, tmr_irq[0]}, 0);

        // R4 re-writing enable does not reload
        wr(8'h00, 32'd50);
        wr(8'h08, 32'h3); e = last_wr;
        repeat (4) @(negedge clk);
        wr(8'h08, 32'h3);
        repeat (3) @(negedge clk);
        wr(8'h08, 32'h2); d = last_wr;
        rd(8'h04, v); chk("R4 no reload", v, exp_cur(50, d - e - 1, 1'b1));

        // R8 mask on timer 1 (base 0x14)
        wr(8'h14, 32'd3);
        wr(8'h1C, 32'h7);
        repeat (10) @(negedge clk);
        chk("R8 irq masked", {31'd0, tmr_irq[1]}, 0);
        rd(8'h24, v); chk("R8 stat", v, 0);
        rd(8'hA0, v); chk("R8 gstat", v, 0);
        rd(8'hA8, v); chk("R8 raw", v, 32'h2);
        wr(8'h1C, 32'h3);
        @(negedge clk);
        chk("R8 unmask irq", {30'd0, irq_any, tmr_irq[1]}, 32'h3);
        wr(8'h1C, 32'h2);

        // R10 shared acknowledge
        rd(8'hA4, v); chk("R10 data", v, 32'h2);
        rd(8'hA8, v); chk("R10 raw", v, 0);
        chk("R11 irq_any low", {31'd0, irq_any}, 0);
        wr(8'h00, 32'd1); wr(8'h14, 32'd1);
        wr(8'h08, 32'h3); wr(8'h1C, 32'h3);
        wr(8'h08, 32'h2); wr(8'h1C, 32'h2);
        rd(8'hA8, v); chk("R10 both raw", v, 32'h3);
        rd(8'hA4, v); chk("R10 both data", v, 32'h3);
        rd(8'hA8, v); chk("R10 both clear", v, 0);

        // R2 / R11 map
        rd(8'hAC, v); chk("R11 version", v, VER);
        rd(8'h30, v); chk("R2 hole", v, 0);
        rd(8'hB0, v); chk("R2 high", v, 0);
        rd(8'h02, v); chk("R2 unaligned", v, 0);
        rd(8'h14, v); chk("R2 t1 load", v, 32'd1);
        chk("R2 pready", {31'd0, pready}, 32'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule